// File: doc/BRIEF.md
# Half-Warp Segment Transaction Reducer

This block turns one memory request from a group of 16 lanes into a series of bus transactions of 32, 64 or 128 bytes. A request carries an active-lane mask, one byte address per lane and a single element size shared by all lanes. The block takes the request through a valid/ready handshake and works through the lanes it has not yet served. For each transaction it takes the lowest-numbered unserved active lane and finds the naturally aligned segment that holds that lane's address. The segment is 32 bytes for byte elements, 64 bytes for halfword elements and 128 bytes for word and doubleword elements. Every unserved lane whose address falls in that segment is served by the same transaction.

Before a transaction goes out, the block checks which bytes of the segment the lanes use. While all of them sit in one half, it narrows the transaction to that half, and it never goes below 32 bytes. Each transaction leaves through its own valid/ready handshake with the aligned start address of the final segment, a size code and the mask of lanes it serves. The served lanes are then removed. A one-cycle done pulse follows the last transaction. Lane addresses are assumed to be aligned to the element size. Data movement and memory timing are handled elsewhere.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset the block is ready for a request (req_ready high), offers no transaction (txn_valid low) and does not assert done.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready stays low from that edge until the request's done pulse, so no second request is taken while transactions are outstanding.
- R3: Each transaction contains the lowest-numbered lane that is active and not yet served.
- R4: Element size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. They select a starting segment of 32, 64, 128 and 128 bytes respectively, aligned to its own size. txn_lanes is exactly the set of unserved active lanes whose address lies in the starting segment of the lowest unserved lane.
- R5: Size codes are 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. Starting from the segment of R4, the size is halved while every byte used by the served lanes lies within one half. The size never drops below 32 bytes.
- R6: txn_addr is the start of the final, possibly reduced, segment and is aligned to that segment's size.
- R7: While txn_valid is high and txn_ready is low, txn_addr, txn_size and txn_lanes hold their values and txn_valid stays high.
- R8: Lanes served by an accepted transaction are never offered again. Inactive lanes are never offered. Every active lane is served exactly once.
- R9: done is high for exactly one cycle, in the cycle after the edge that accepts the last transaction. For a request with an all-zero mask, done is high in the cycle after the request is taken, and no transaction is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mask | input | LANES | Active lanes of the request |
| req_addr | input | LANES*AW | Byte address per lane, lane i at bits [i*AW +: AW] |
| req_esize | input | 2 | Element size code (R4) |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction accepted by the downstream side |
| txn_addr | output | AW | Aligned start address of the transaction |
| txn_size | output | 2 | Transaction size code (R5) |
| txn_lanes | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse after the request is fully served |

## Verification
The bench sweeps every element size over contiguous, shifted, strided, broadcast, reversed, scattered, upper-half-only and one-segment-per-lane address patterns, each under several lane masks, and it also sends an all-zero mask. Upper-half-only and shifted patterns target the reduction step. A design that always stays at the lower half, or keeps the 128-byte address, would report a wrong address or size there. Reversed and one-segment-per-lane patterns check the serving order and the mask clearing: a design that picked the highest lane first, or failed to clear served lanes, would emit transactions out of order or repeat them. Stalled handshakes and the all-zero mask check that outputs hold while stalled and that the done pulse comes exactly one cycle after the last transaction (or after the request when the mask is empty), not early and not late.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  localparam int unsigned MIN_SEG_LOG2 = 5;

  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txn_sz_e;

  typedef enum logic [1:0] {
    EL_B1 = 2'd0,
    EL_B2 = 2'd1,
    EL_B4 = 2'd2,
    EL_B8 = 2'd3
  } elem_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_e;

  function automatic txn_sz_e start_level(elem_e e);
    case (e)
      EL_B1:   return SZ_32;
      EL_B2:   return SZ_64;
      default: return SZ_128;
    endcase
  endfunction

endpackage

// File: rtl/hwc_lane_pick.sv
module hwc_lane_pick #(
  parameter int LANES = 16,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic             found,
  output logic [LW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = LW'(i);
      end
    end
  end

endmodule

// File: rtl/hwc_seg_match.sv
module hwc_seg_match #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr,
  input  logic [AW-1:0]       lead_addr,
  input  hwc_pkg::txn_sz_e    level,
  output logic [LANES-1:0]    hit
);

  logic [AW-1:0] seg_keep;
  logic [AW-1:0] lead_seg;

  assign seg_keep = ~((AW'(32) << level) - AW'(1));
  assign lead_seg = lead_addr & seg_keep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] lane_seg;
    assign lane_seg = addr[g*AW +: AW] & seg_keep;
    assign hit[g]   = pend[g] && (lane_seg == lead_seg);
  end

endmodule

// File: rtl/hwc_size_reduce.sv
module hwc_size_reduce #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    hit,
  input  logic [LANES*AW-1:0] addr,
  input  logic [AW-1:0]       lead_addr,
  input  hwc_pkg::txn_sz_e    start_lvl,
  output hwc_pkg::txn_sz_e    final_lvl,
  output logic [AW-1:0]       base_addr
);
  import hwc_pkg::*;

  logic lo6, hi6, lo5, hi5;

  always_comb begin
    lo6 = 1'b0;
    hi6 = 1'b0;
    lo5 = 1'b0;
    hi5 = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (hit[i]) begin
        lo6 = lo6 | ~addr[i*AW + 6];
        hi6 = hi6 |  addr[i*AW + 6];
        lo5 = lo5 | ~addr[i*AW + 5];
        hi5 = hi5 |  addr[i*AW + 5];
      end
    end
  end

  txn_sz_e mid_lvl;

  always_comb begin
    mid_lvl = start_lvl;
    if (start_lvl == SZ_128 && !(lo6 && hi6)) mid_lvl = SZ_64;
    final_lvl = mid_lvl;
    if (mid_lvl == SZ_64 && !(lo5 && hi5)) final_lvl = SZ_32;
  end

  assign base_addr = lead_addr & ~((AW'(32) << final_lvl) - AW'(1));

endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_mask,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [1:0]          req_esize,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_addr,
  output logic [1:0]          txn_size,
  output logic [LANES-1:0]    txn_lanes,
  output logic                done
);
  import hwc_pkg::*;

  localparam int LW = $clog2(LANES);

  state_e              st_q, st_d;
  logic [LANES-1:0]    pend_q, pend_d;
  logic                done_q, done_d;
  logic [LANES*AW-1:0] addr_q;
  elem_e               esz_q;

  logic                found;
  logic [LW-1:0]       lead_idx;
  logic [AW-1:0]       lead_addr;
  txn_sz_e             start_lvl, final_lvl;
  logic [LANES-1:0]    hit;
  logic [AW-1:0]       base_addr;
  logic                load_en, txn_fire;

  hwc_lane_pick #(.LANES(LANES)) u_pick (
    .pend  (pend_q),
    .found (found),
    .idx   (lead_idx)
  );

  assign lead_addr = addr_q[lead_idx*AW +: AW];
  assign start_lvl = start_level(esz_q);

  hwc_seg_match #(.LANES(LANES), .AW(AW)) u_match (
    .pend      (pend_q),
    .addr      (addr_q),
    .lead_addr (lead_addr),
    .level     (start_lvl),
    .hit       (hit)
  );

  hwc_size_reduce #(.LANES(LANES), .AW(AW)) u_reduce (
    .hit       (hit),
    .addr      (addr_q),
    .lead_addr (lead_addr),
    .start_lvl (start_lvl),
    .final_lvl (final_lvl),
    .base_addr (base_addr)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign txn_valid = (st_q == ST_BUSY) && found;
  assign txn_addr  = base_addr;
  assign txn_size  = final_lvl;
  assign txn_lanes = hit;
  assign done      = done_q;

  assign load_en  = req_valid && req_ready;
  assign txn_fire = txn_valid && txn_ready;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (load_en) begin
          pend_d = req_mask;
          if (req_mask == '0) done_d = 1'b1;
          else                st_d   = ST_BUSY;
        end
      end
      default: begin
        if (txn_fire) begin
          pend_d = pend_q & ~hit;
          if (pend_d == '0) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= req_addr;
      esz_q  <= elem_e'(req_esize);
    end
  end

endmodule

// File: rtl/hwc_coalescer_sva.sv
module hwc_coalescer_sva #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [AW-1:0]    txn_addr,
  input logic [1:0]       txn_size,
  input logic [LANES-1:0] txn_lanes,
  input logic             done,
  input logic [LANES-1:0] pend
);

  // R2: no request taken while a transaction is outstanding
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  // R7: stalled transaction holds
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr)
      && $stable(txn_size) && $stable(txn_lanes)));

  // R6: address aligned to the offered size
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_addr & ((AW'(32) << txn_size) - AW'(1))) == '0));

  // R5: only the three legal size codes
  a_r5_size_code: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_size != 2'd3));

  // R3: lowest pending lane is always in the offered lanes
  a_r3_lead_lane: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes & (pend & (~pend + LANES'(1)))) != '0));

  // R8: only pending lanes are offered; served lanes are gone next cycle
  a_r8_subset: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes & ~pend) == '0));

  a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> ((pend & $past(txn_lanes)) == '0));

  // R9: done is a single-cycle pulse with nothing offered
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txn_valid && req_ready));

endmodule

bind hwc_coalescer hwc_coalescer_sva #(.LANES(LANES), .AW(AW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .txn_valid (txn_valid),
  .txn_ready (txn_ready),
  .txn_addr  (txn_addr),
  .txn_size  (txn_size),
  .txn_lanes (txn_lanes),
  .done      (done),
  .pend      (pend_q)
);

// File: tb/hwc_coalescer_tb.sv
module hwc_coalescer_tb;

  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk;
  logic                rst_n;
  logic                req_valid;
  logic                req_ready;
  logic [LANES-1:0]    req_mask;
  logic [LANES*AW-1:0] req_addr;
  logic [1:0]          req_esize;
  logic                txn_valid;
  logic                txn_ready;
  logic [AW-1:0]       txn_addr;
  logic [1:0]          txn_size;
  logic [LANES-1:0]    txn_lanes;
  logic                done;

  int n_checks = 0;
  int n_fail   = 0;
  int stall_ctr = 0;
  logic [31:0] lcg = 32'h1234_5678;

  logic [31:0] la [LANES];
  logic [31:0] exp_addr [LANES];
  int          exp_size [LANES];
  logic [15:0] exp_lanes [LANES];
  int          n_exp;

  hwc_coalescer #(.LANES(LANES), .AW(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .req_addr  (req_addr),
    .req_esize (req_esize),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_addr  (txn_addr),
    .txn_size  (txn_size),
    .txn_lanes (txn_lanes),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Reference: arithmetic model of the serving order and reduction
  task automatic build_expect(input logic [15:0] mask, input int es);
    logic [15:0] pend;
    int ebytes, seg, lead, lo, hi, off;
    logic [31:0] base;
    pend   = mask;
    n_exp  = 0;
    ebytes = 1 << es;
    seg    = (es == 0) ? 32 : (es == 1) ? 64 : 128;
    while (pend != 0) begin
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      base = (la[lead] / seg) * seg;
      exp_lanes[n_exp] = '0;
      lo = 1000;
      hi = -1;
      for (int i = 0; i < LANES; i++) begin
        if (pend[i] && ((la[i] / seg) * seg) == base) begin
          exp_lanes[n_exp][i] = 1'b1;
          off = int'(la[i] - base);
          if (off < lo) lo = off;
          if (off + ebytes - 1 > hi) hi = off + ebytes - 1;
        end
      end
      begin
        int sz;
        sz = seg;
        while (sz > 32) begin
          if (hi < sz / 2) begin
            sz = sz / 2;
          end else if (lo >= sz / 2) begin
            base = base + 32'(sz / 2);
            lo   = lo - sz / 2;
            hi   = hi - sz / 2;
            sz   = sz / 2;
          end else begin
            break;
          end
        end
        exp_size[n_exp] = (sz == 32) ? 0 : (sz == 64) ? 1 : 2;
      end
      exp_addr[n_exp] = base;
      pend = pend & ~exp_lanes[n_exp];
      n_exp++;
    end
  endtask

  task automatic run_req(input logic [15:0] mask, input int es);
    int idx;
    build_expect(mask, es);
    @(negedge clk);
    chk("R2 ready before request", 32'(req_ready), 32'd1);
    chk("R9 no done before request", 32'(done), 32'd0);
    req_valid = 1'b1;
    req_mask  = mask;
    req_esize = 2'(es);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = la[i];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_mask  = '1;
    idx = 0;
    while (1) begin
      if (idx == n_exp) begin
        chk("R9 done after last", 32'(done), 32'd1);
        chk("R8 nothing left", 32'(txn_valid), 32'd0);
        txn_ready = 1'b0;
        break;
      end
      chk("R9 done low while busy", 32'(done), 32'd0);
      chk("R2 ready low while busy", 32'(req_ready), 32'd0);
      chk("R8 txn offered", 32'(txn_valid), 32'd1);
      chk("R3 R4 R8 lane mask", 32'(txn_lanes), 32'(exp_lanes[idx]));
      chk("R6 txn address", txn_addr, exp_addr[idx]);
      chk("R5 txn size", 32'(txn_size), 32'(exp_size[idx]));
      stall_ctr++;
      if (stall_ctr % 3 == 1) begin
        txn_ready = 1'b0; // R7 stall: same values must be seen next cycle
      end else begin
        txn_ready = 1'b1;
        idx++;
      end
      @(posedge clk);
      @(negedge clk);
    end
    @(negedge clk);
    chk("R9 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic make_addrs(input int pat, input int es, input logic [31:0] b);
    int e;
    e = 1 << es;
    for (int i = 0; i < LANES; i++) begin
      case (pat)
        0: la[i] = b + 32'(i * e);
        1: la[i] = b + 32'((i + 3) * e);
        2: la[i] = b + 32'(2 * i * e);
        3: la[i] = b;
        4: la[i] = b + 32'((15 - i) * e);
        5: begin
          lcg   = lcg * 32'd1103515245 + 32'd12345;
          la[i] = b + ((lcg >> 8) & 32'h3FF) * 32'(e);
        end
        6: la[i] = b + 32'd64 + 32'((i % 4) * e);
        default: la[i] = b + 32'(i * 128);
      endcase
    end
  endtask

  initial begin
    logic [15:0] masks [4];
    masks[0] = 16'hFFFF;
    masks[1] = 16'hA5F0;
    masks[2] = 16'h0100;
    masks[3] = 16'h7FFE;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_mask  = '0;
    req_addr  = '0;
    req_esize = '0;
    txn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 no txn after reset", 32'(txn_valid), 32'd0);
    chk("R1 no done after reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'(txn_valid), 32'd0);

    for (int es = 0; es < 4; es++) begin
      for (int pat = 0; pat < 8; pat++) begin
        for (int m = 0; m < 4; m++) begin
          make_addrs(pat, es, 32'h0000_4000 + 32'(m * 32'h200) + 32'(pat * 32'h1000));
          run_req(masks[m], es);
        end
      end
    end

    // R9: empty mask gives done with no transaction
    make_addrs(0, 2, 32'h8000);
    run_req(16'h0000, 2);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

endmodule